// File: doc/BRIEF.md
# FIFO Fill-Level Flag Unit

This block produces the three fill-level status flags of a dual-clock FIFO: almost-full, almost-empty and half-full. It does not hold the FIFO storage. Each clock domain supplies its own view of the occupancy: the write domain provides `wr_count_i` and the read domain provides `rd_count_i`. In fall-through mode each count includes the word held in the output register. The fall-through selection is a static input. All three flags are active low.

Two offset registers set the almost thresholds. The empty offset sets where almost-empty asserts, and the full offset sets where almost-full asserts. The level of `ld_i` while reset is held chooses the default value of both offsets and the only programming method that will be accepted until the next reset. That method is either a serial bit stream on the write clock or parallel writes. Parallel read-back works in both methods. After reset, `ld_i` low opens a programming window. Parallel accesses alternate between the empty offset and the full offset. A serial stream fills the empty offset first and the full offset second.

Reset is asynchronous for the flags and the sequencing state. The offsets and the method are captured on write-clock edges while `rst_ni` is low, so the write clock must run for at least one edge during reset.

Top module: `fifo_flag_unit`

## Requirements
- R1: The method and the defaults are taken from `ld_i` on write-clock edges while `rst_ni` is low. With `ld_i` low, both offsets become 127 and parallel programming is selected. With `ld_i` high, both offsets become 1023 and serial programming is selected. Neither changes until the next reset.
- R2: A parallel write (`prog_wr_i`) is ignored in serial method, and a serial stream is ignored in parallel method. A parallel read (`prog_rd_i` with `ld_i` low) returns an offset on `off_rdata_o` one write-clock edge later, in either method.
- R3: In serial method, each write-clock edge with `ld_i` and `sen_i` both low shifts `si_i` into the offsets, least significant bit first. The first OFF_W bits go to the empty offset and the next OFF_W bits go to the full offset. Further bits are dropped. `sen_i` high holds the offsets. `ld_i` high restarts the bit count for the next stream.
- R4: `almost_full_no` is registered on the write clock. It is 0 when wr_count + full_offset >= DEPTH + f, and 1 otherwise, where f is 1 in fall-through mode and 0 in standard mode.
- R5: `almost_empty_no` is registered on the read clock. It is 0 when rd_count <= empty_offset + f, and 1 otherwise.
- R6: The threshold for `half_full_no` is DEPTH/2 + f. `half_full_no` goes to 0 on the write-clock edge that sees `wr_count_i` above the threshold after having seen it at or below. It returns to 1 on the read-clock edge that sees `rd_count_i` at or below the threshold after having seen it above.
- R7: While `rst_ni` is low, `almost_full_no` is 1, `half_full_no` is 1 and `almost_empty_no` is 0.
- R8: A one-bit selector chooses the target of a parallel access: 0 is the empty offset and 1 is the full offset. The selector clears whenever `ld_i` is high and toggles on each accepted parallel write or read. If `prog_wr_i` and `prog_rd_i` are high together, the write is performed and the read is not, so `off_rdata_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-domain clock |
| rclk_i | input | 1 | Read-domain clock |
| rst_ni | input | 1 | Active-low master reset |
| fall_through_i | input | 1 | 1 selects fall-through mode, 0 selects standard mode |
| ld_i | input | 1 | Selects the method during reset; opens the programming window when low after reset |
| sen_i | input | 1 | Active-low serial shift enable |
| si_i | input | 1 | Serial offset data |
| prog_wr_i | input | 1 | Parallel offset write strobe |
| prog_rd_i | input | 1 | Parallel offset read strobe |
| off_wdata_i | input | OFF_W | Parallel offset write data |
| wr_count_i | input | CNT_W | Occupancy seen by the write domain |
| rd_count_i | input | CNT_W | Occupancy seen by the read domain |
| off_rdata_o | output | OFF_W | Parallel offset read data |
| almost_full_no | output | 1 | Almost-full flag, active low |
| almost_empty_no | output | 1 | Almost-empty flag, active low |
| half_full_no | output | 1 | Half-full flag, active low, set and cleared from both domains |

## Verification
The bench walks both almost thresholds one word either side of the boundary in standard and fall-through mode.

- A design that does not add the fall-through word would flip the flags one count early.
- Offsets are reprogrammed and the thresholds retested, so a comparator tied to the defaults would be caught.
- Each method is driven with the other method's stimulus, and read-back shows the offsets unchanged. A design that accepted the wrong method would show altered values.
- A serial stream carries more bits than fit, and a pause with `sen_i` high sits in the middle of it. Shifting past the end or during the pause would corrupt the read-back values.
- Half-full is tested at its threshold in both modes. Its release is tested through the read-side count, which catches a flag cleared from the wrong domain or at the wrong count.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;
  typedef enum logic {
    SEL_EMPTY = 1'b0,
    SEL_FULL  = 1'b1
  } off_sel_e;
endpackage

// File: rtl/fifo_flag_sync.sv
module fifo_flag_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fifo_flag_offsets.sv
module fifo_flag_offsets
  import fifo_flag_pkg::*;
#(
  parameter int unsigned      OFF_W   = 10,
  parameter logic [OFF_W-1:0] DEF_PAR = OFF_W'(127),
  parameter logic [OFF_W-1:0] DEF_SER = OFF_W'(1023)
) (
  input  logic             wclk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic             sen_i,
  input  logic             si_i,
  input  logic             prog_wr_i,
  input  logic             prog_rd_i,
  input  logic [OFF_W-1:0] wdata_i,
  output logic [OFF_W-1:0] empty_off_o,
  output logic [OFF_W-1:0] full_off_o,
  output logic [OFF_W-1:0] rdata_o,
  output logic             serial_mode_o
);
  localparam int unsigned TOTAL_BITS = 2 * OFF_W;
  localparam int unsigned BIT_CNT_W  = $clog2(TOTAL_BITS + 1);

  logic                 serial_q;
  logic [OFF_W-1:0]     empty_q, full_q, rdata_q;
  logic [BIT_CNT_W-1:0] bit_cnt_q;
  off_sel_e             sel_q;
  logic                 shift_en, par_wr, par_rd, in_empty_half;

  assign shift_en      = serial_q && !ld_i && !sen_i && (bit_cnt_q != BIT_CNT_W'(TOTAL_BITS));
  assign in_empty_half = bit_cnt_q < BIT_CNT_W'(OFF_W);
  assign par_wr        = !serial_q && !ld_i && prog_wr_i;
  assign par_rd        = !ld_i && prog_rd_i && !par_wr;

  // method and defaults captured on clock edges while reset is held
  always_ff @(posedge wclk_i) begin
    if (!rst_ni) begin
      serial_q <= ld_i;
      empty_q  <= ld_i ? DEF_SER : DEF_PAR;
      full_q   <= ld_i ? DEF_SER : DEF_PAR;
    end else if (shift_en) begin
      if (in_empty_half) empty_q <= {si_i, empty_q[OFF_W-1:1]};
      else               full_q  <= {si_i, full_q[OFF_W-1:1]};
    end else if (par_wr) begin
      if (sel_q == SEL_EMPTY) empty_q <= wdata_i;
      else                    full_q  <= wdata_i;
    end
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      sel_q     <= SEL_EMPTY;
      rdata_q   <= '0;
    end else if (ld_i) begin
      bit_cnt_q <= '0;
      sel_q     <= SEL_EMPTY;
    end else begin
      if (shift_en)        bit_cnt_q <= bit_cnt_q + 1'b1;
      if (par_wr || par_rd) sel_q    <= (sel_q == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
      if (par_rd)          rdata_q   <= (sel_q == SEL_EMPTY) ? empty_q : full_q;
    end
  end

  assign empty_off_o   = empty_q;
  assign full_off_o    = full_q;
  assign rdata_o       = rdata_q;
  assign serial_mode_o = serial_q;
endmodule

// File: rtl/fifo_flag_almost.sv
module fifo_flag_almost #(
  parameter int unsigned DEPTH   = 2048,
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned OFF_W   = 10,
  parameter bit          IS_FULL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fwft_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             flag_no
);
  localparam int unsigned CMP_W = ((CNT_W > OFF_W) ? CNT_W : OFF_W) + 2;

  logic hit;
  logic flag_q;

  generate
    if (IS_FULL) begin : g_full
      // sum form avoids underflow when the offset exceeds the depth
      assign hit = (CMP_W'(count_i) + CMP_W'(off_i)) >= (CMP_W'(DEPTH) + CMP_W'(fwft_i));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flag_q <= 1'b1;
        else         flag_q <= ~hit;
      end
    end else begin : g_empty
      assign hit = CMP_W'(count_i) <= (CMP_W'(off_i) + CMP_W'(fwft_i));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flag_q <= 1'b0;
        else         flag_q <= ~hit;
      end
    end
  endgenerate

  assign flag_no = flag_q;
endmodule

// File: rtl/fifo_flag_half.sv
module fifo_flag_half #(
  parameter int unsigned DEPTH       = 2048,
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             fwft_i,
  input  logic [CNT_W-1:0] wr_count_i,
  input  logic [CNT_W-1:0] rd_count_i,
  output logic             half_full_no
);
  logic [CNT_W-1:0] thr;
  logic w_tog_q, w_arm_q, r_tog_q, r_arm_q;
  logic r_tog_ws, w_tog_rs;
  logic w_above, r_above;

  assign thr     = CNT_W'(DEPTH / 2) + CNT_W'(fwft_i);
  assign w_above = wr_count_i > thr;
  assign r_above = rd_count_i > thr;

  fifo_flag_sync #(.STAGES(SYNC_STAGES)) i_sync_r2w (
    .clk_i (wclk_i), .rst_ni(rst_ni), .d_i(r_tog_q), .q_o(r_tog_ws)
  );
  fifo_flag_sync #(.STAGES(SYNC_STAGES)) i_sync_w2r (
    .clk_i (rclk_i), .rst_ni(rst_ni), .d_i(w_tog_q), .q_o(w_tog_rs)
  );

  // set side: toggle once per upward crossing while the flag is released
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_tog_q <= 1'b0;
      w_arm_q <= 1'b1;
    end else if (w_above && w_arm_q && (w_tog_q == r_tog_ws)) begin
      w_tog_q <= ~w_tog_q;
      w_arm_q <= 1'b0;
    end else if (!w_above) begin
      w_arm_q <= 1'b1;
    end
  end

  // clear side: toggle once per downward crossing while the flag is set
  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_tog_q <= 1'b0;
      r_arm_q <= 1'b0;
    end else if (!r_above && r_arm_q && (r_tog_q != w_tog_rs)) begin
      r_tog_q <= ~r_tog_q;
      r_arm_q <= 1'b0;
    end else if (r_above) begin
      r_arm_q <= 1'b1;
    end
  end

  assign half_full_no = ~(w_tog_q ^ r_tog_q);
endmodule

// File: rtl/fifo_flag_unit.sv
module fifo_flag_unit #(
  parameter int unsigned      DEPTH       = 2048,
  parameter int unsigned      OFF_W       = 10,
  parameter logic [OFF_W-1:0] DEF_PAR     = OFF_W'(127),
  parameter logic [OFF_W-1:0] DEF_SER     = OFF_W'(1023),
  parameter int unsigned      SYNC_STAGES = 2,
  localparam int unsigned     CNT_W       = $clog2(DEPTH + 2)
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             fall_through_i,
  input  logic             ld_i,
  input  logic             sen_i,
  input  logic             si_i,
  input  logic             prog_wr_i,
  input  logic             prog_rd_i,
  input  logic [OFF_W-1:0] off_wdata_i,
  input  logic [CNT_W-1:0] wr_count_i,
  input  logic [CNT_W-1:0] rd_count_i,
  output logic [OFF_W-1:0] off_rdata_o,
  output logic             almost_full_no,
  output logic             almost_empty_no,
  output logic             half_full_no
);
  logic [OFF_W-1:0] empty_off, full_off;
  logic             serial_mode;

  fifo_flag_offsets #(
    .OFF_W(OFF_W), .DEF_PAR(DEF_PAR), .DEF_SER(DEF_SER)
  ) i_offsets (
    .wclk_i       (wclk_i),
    .rst_ni       (rst_ni),
    .ld_i         (ld_i),
    .sen_i        (sen_i),
    .si_i         (si_i),
    .prog_wr_i    (prog_wr_i),
    .prog_rd_i    (prog_rd_i),
    .wdata_i      (off_wdata_i),
    .empty_off_o  (empty_off),
    .full_off_o   (full_off),
    .rdata_o      (off_rdata_o),
    .serial_mode_o(serial_mode)
  );

  fifo_flag_almost #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .OFF_W(OFF_W), .IS_FULL(1'b1)
  ) i_paf (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .fwft_i (fall_through_i),
    .count_i(wr_count_i),
    .off_i  (full_off),
    .flag_no(almost_full_no)
  );

  fifo_flag_almost #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .OFF_W(OFF_W), .IS_FULL(1'b0)
  ) i_pae (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .fwft_i (fall_through_i),
    .count_i(rd_count_i),
    .off_i  (empty_off),
    .flag_no(almost_empty_no)
  );

  fifo_flag_half #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)
  ) i_half (
    .wclk_i      (wclk_i),
    .rclk_i      (rclk_i),
    .rst_ni      (rst_ni),
    .fwft_i      (fall_through_i),
    .wr_count_i  (wr_count_i),
    .rd_count_i  (rd_count_i),
    .half_full_no(half_full_no)
  );
endmodule

// File: rtl/fifo_flag_unit_chk.sv
module fifo_flag_unit_chk #(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned OFF_W = 10,
  parameter int unsigned CNT_W = 12
) (
  input logic             wclk_i,
  input logic             rclk_i,
  input logic             rst_ni,
  input logic             fall_through_i,
  input logic             ld_i,
  input logic             sen_i,
  input logic             prog_wr_i,
  input logic [CNT_W-1:0] wr_count_i,
  input logic [CNT_W-1:0] rd_count_i,
  input logic [OFF_W-1:0] empty_off,
  input logic [OFF_W-1:0] full_off,
  input logic             serial_mode,
  input logic             almost_full_no,
  input logic             almost_empty_no,
  input logic             half_full_no
);
  AST_RESET_FLAGS: assert property (@(posedge wclk_i) !rst_ni |-> (almost_full_no && half_full_no && !almost_empty_no)); // R7

  AST_METHOD_HELD: assert property (@(posedge wclk_i) disable iff (!rst_ni) 1'b1 |=> $stable(serial_mode)); // R1

  AST_PAR_WR_IGNORED: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (serial_mode && sen_i && prog_wr_i) |=> ($stable(empty_off) && $stable(full_off))); // R2

  AST_SER_IGNORED: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!serial_mode && !prog_wr_i) |=> ($stable(empty_off) && $stable(full_off))); // R2

  AST_LD_HIGH_HOLDS: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ld_i |=> ($stable(empty_off) && $stable(full_off))); // R3

  AST_PAF_SET: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (int'(wr_count_i) + int'(full_off) >= int'(DEPTH) + int'(fall_through_i)) |=> !almost_full_no); // R4

  AST_PAF_CLR: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (int'(wr_count_i) + int'(full_off) < int'(DEPTH) + int'(fall_through_i)) |=> almost_full_no); // R4

  AST_PAE_SET: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (int'(rd_count_i) <= int'(empty_off) + int'(fall_through_i)) |=> !almost_empty_no); // R5

  AST_PAE_CLR: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (int'(rd_count_i) > int'(empty_off) + int'(fall_through_i)) |=> almost_empty_no); // R5

  AST_HF_FALL: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $fell(half_full_no) |-> (int'($past(wr_count_i)) > int'(DEPTH / 2) + int'($past(fall_through_i)))); // R6

  AST_HF_RISE: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $rose(half_full_no) |-> (int'($past(rd_count_i)) <= int'(DEPTH / 2) + int'($past(fall_through_i)))); // R6
endmodule

bind fifo_flag_unit fifo_flag_unit_chk #(
  .DEPTH(DEPTH), .OFF_W(OFF_W), .CNT_W(CNT_W)
) i_chk (
  .wclk_i         (wclk_i),
  .rclk_i         (rclk_i),
  .rst_ni         (rst_ni),
  .fall_through_i (fall_through_i),
  .ld_i           (ld_i),
  .sen_i          (sen_i),
  .prog_wr_i      (prog_wr_i),
  .wr_count_i     (wr_count_i),
  .rd_count_i     (rd_count_i),
  .empty_off      (empty_off),
  .full_off       (full_off),
  .serial_mode    (serial_mode),
  .almost_full_no (almost_full_no),
  .almost_empty_no(almost_empty_no),
  .half_full_no   (half_full_no)
);

// File: tb/test_fifo_flag_unit.sv
module test_fifo_flag_unit;
  localparam int unsigned DEPTH = 2048;
  localparam int unsigned OFF_W = 10;
  localparam int unsigned CNT_W = $clog2(DEPTH + 2);
  localparam int unsigned NVEC  = 7;

  // {fall_through, wr_count, rd_count, exp almost_full_no, exp almost_empty_no}, offsets 127
  localparam logic [26:0] VEC [NVEC] = '{
    {1'b0, 12'd1920, 12'd128,  1'b1, 1'b1},
    {1'b0, 12'd1921, 12'd127,  1'b0, 1'b0},
    {1'b1, 12'd1921, 12'd128,  1'b1, 1'b0},
    {1'b1, 12'd1922, 12'd129,  1'b0, 1'b1},
    {1'b0, 12'd0,    12'd0,    1'b1, 1'b0},
    {1'b1, 12'd2049, 12'd2049, 1'b0, 1'b1},
    {1'b0, 12'd1024, 12'd1024, 1'b1, 1'b1}
  };

  logic             clk = 1'b0;
  logic             rst_ni = 1'b1;
  logic             fwft = 1'b0, ld = 1'b0, sen = 1'b1, si = 1'b0;
  logic             prog_wr = 1'b0, prog_rd = 1'b0;
  logic [OFF_W-1:0] wdata = '0;
  logic [CNT_W-1:0] wc = '0, rc = '0;
  logic [OFF_W-1:0] rdata;
  logic             paf_n, pae_n, hf_n;
  int               n_chk = 0, n_fail = 0;
  bit               done = 1'b0;

  always #4 clk = ~clk;

  fifo_flag_unit #(.DEPTH(DEPTH), .OFF_W(OFF_W)) i_fifo_flag_unit (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_ni), .fall_through_i(fwft),
    .ld_i(ld), .sen_i(sen), .si_i(si), .prog_wr_i(prog_wr), .prog_rd_i(prog_rd),
    .off_wdata_i(wdata), .wr_count_i(wc), .rd_count_i(rc),
    .off_rdata_o(rdata), .almost_full_no(paf_n), .almost_empty_no(pae_n),
    .half_full_no(hf_n)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(logic ld_level);
    ld = ld_level; rst_ni = 1'b0;
    tick(); tick(); tick();
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic read_pair(string req, int exp_e, int exp_f);
    ld = 1'b1; tick();
    ld = 1'b0; prog_rd = 1'b1; tick();
    check(req, "readback empty offset", int'(rdata), exp_e);
    tick();
    check(req, "readback full offset", int'(rdata), exp_f);
    prog_rd = 1'b0; ld = 1'b1; tick();
  endtask

  task automatic shift_word(int val);
    for (int b = 0; b < OFF_W; b++) begin
      si = val[b]; tick();
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    tick(); tick(); tick();
    // R7: flag values during reset
    check("R7", "almost_full_no in reset", paf_n, 1);
    check("R7", "half_full_no in reset", hf_n, 1);
    check("R7", "almost_empty_no in reset", pae_n, 0);
    rst_ni = 1'b1; tick();
    read_pair("R1", 127, 127);

    // R4 R5 threshold table
    for (int i = 0; i < NVEC; i++) begin
      {fwft, wc, rc} = VEC[i][26:2];
      tick();
      check("R4", $sformatf("vector %0d almost_full_no", i), paf_n, int'(VEC[i][1]));
      check("R5", $sformatf("vector %0d almost_empty_no", i), pae_n, int'(VEC[i][0]));
    end
    fwft = 1'b0; wc = '0; rc = '0; tick();

    // R8: alternating parallel writes
    ld = 1'b1; tick();
    ld = 1'b0; prog_wr = 1'b1;
    wdata = 10'd5;   tick();
    wdata = 10'd300; tick();
    prog_wr = 1'b0; ld = 1'b1; tick();
    read_pair("R8", 5, 300);
    // R8: write wins over a simultaneous read
    ld = 1'b0; prog_wr = 1'b1; prog_rd = 1'b1; wdata = 10'd9; tick();
    check("R8", "rdata held on simultaneous write", int'(rdata), 300);
    prog_wr = 1'b0; prog_rd = 1'b0; ld = 1'b1; tick();
    read_pair("R8", 9, 300);

    // R5 R4 with programmed offsets (empty 9, full 300)
    rc = 12'd9;    tick(); check("R5", "pae at programmed offset", pae_n, 0);
    rc = 12'd10;   tick(); check("R5", "pae above programmed offset", pae_n, 1);
    wc = 12'd1748; tick(); check("R4", "paf at programmed offset", paf_n, 0);
    wc = 12'd1747; tick(); check("R4", "paf below programmed offset", paf_n, 1);
    wc = '0; rc = '0;

    // R2: serial stream ignored in parallel method
    ld = 1'b0; sen = 1'b0; si = 1'b1;
    for (int k = 0; k < 25; k++) tick();
    sen = 1'b1; ld = 1'b1; tick();
    read_pair("R2", 9, 300);

    // R1: serial method, defaults 1023
    do_reset(1'b1);
    read_pair("R1", 1023, 1023);
    // R2: parallel write ignored in serial method
    ld = 1'b0; prog_wr = 1'b1; wdata = 10'd7; tick(); tick();
    prog_wr = 1'b0; ld = 1'b1; tick();
    read_pair("R2", 1023, 1023);

    // R3: serial stream with a pause and surplus bits
    ld = 1'b0; sen = 1'b0;
    for (int b = 0; b < 4; b++) begin si = 37 >> b; tick(); end
    sen = 1'b1; si = 1'b1; tick(); tick(); tick();
    sen = 1'b0;
    for (int b = 4; b < OFF_W; b++) begin si = 37 >> b; tick(); end
    shift_word(600);
    si = 1'b1;
    for (int k = 0; k < 5; k++) tick();
    sen = 1'b1; ld = 1'b1; tick();
    read_pair("R3", 37, 600);

    // R6: half-full in standard then fall-through mode
    do_reset(1'b0);
    fwft = 1'b0;
    wc = 12'd1024; tick(); check("R6", "hf at half depth", hf_n, 1);
    wc = 12'd1025; tick(); check("R6", "hf above half depth", hf_n, 0);
    rc = 12'd1025; tick(); tick(); tick(); tick();
    check("R6", "hf held while read count above", hf_n, 0);
    rc = 12'd1024; tick(); check("R6", "hf released by read side", hf_n, 1);
    wc = 12'd1024; tick();
    fwft = 1'b1;
    wc = 12'd1025; tick(); check("R6", "hf fall-through at threshold", hf_n, 1);
    wc = 12'd1026; tick(); check("R6", "hf fall-through above threshold", hf_n, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule